// File: doc/BRIEF.md
# LIN Bus Low-Power Wake Detector

This block watches the receive level of a LIN bus line while the device sits in one of two low-power modes, and decides when the bus has signalled a wake-up. A wake-up counts only when the bus has been held dominant (low) for at least a programmable number of clock cycles and then returns to recessive (high). The same bus event produces a single-cycle interrupt pulse in stop mode and a single-cycle system reset request in sleep mode. Either outcome also sets a sticky source flag that stays set until a clear strobe arrives.

The raw bus level is asynchronous to the clock and passes through a two-flop synchronizer. While either low-power mode is active, the transmitter enable output is held off. The receive-only control bit is sampled on entry into a low-power mode. If it was set at entry, wake detection stays off for the rest of that low-power stay. In stop mode the receive output then tracks the bus level.

Progress toward a wake-up is discarded whenever the mode returns to normal. A dominant level that was already present when a low-power mode was entered is ignored until the bus has been seen recessive at least once.

Top module: `lin_wake_detector`

## Requirements
- R1: `tx_en_o` is 0 one cycle after `mode_i` is stop (2'b01) or sleep (2'b10). In normal mode (2'b00, and also 2'b11) it equals the inverse of `rx_only_i`, one cycle later.
- R2: A wake-up is recognised only if the synchronized bus level stays 0 for at least `MIN_DOM_CYCLES` consecutive clock cycles and then returns to 1. A shorter dominant phase produces no output pulse. The pulse appears on the third rising clock edge after `bus_rx_i` goes high.
- R3: In stop mode a recognised wake-up gives a one-cycle pulse on `wake_irq_o` and nothing on `wake_rst_o`.
- R4: In sleep mode a recognised wake-up gives a one-cycle pulse on `wake_rst_o` and nothing on `wake_irq_o`.
- R5: `wake_src_o` becomes 1 in the same cycle as any wake pulse. It stays 1 until a cycle with `src_clr_i` = 1, after which it reads 0. An event in the same cycle as the strobe keeps it set.
- R6: If `rx_only_i` is 1 in the first cycle of a low-power stay, no wake pulse is produced during that stay, even if `rx_only_i` later drops to 0.
- R7: `rxd_o` follows the synchronized bus with a three-edge latency in normal mode, and in stop mode when the receive-only bit was latched at entry. In every other low-power case it reads 1.
- R8: A dominant phase that began before a low-power mode was entered produces no wake pulse. Returning to normal mode discards any dominant time already counted.
- R9: The dominant-time counter saturates, so a dominant phase many times longer than `MIN_DOM_CYCLES` still gives exactly one wake pulse.
- R10: Synchronous active-high reset drives `tx_en_o`, `wake_irq_o`, `wake_rst_o` and `wake_src_o` to 0, and `rxd_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rx_i | input | 1 | Raw bus receive level, 0 = dominant |
| mode_i | input | 2 | 00 normal, 01 stop, 10 sleep, 11 treated as normal |
| rx_only_i | input | 1 | Receive-only control bit |
| src_clr_i | input | 1 | Clear strobe for the wake source flag |
| tx_en_o | output | 1 | Transmitter enable |
| rxd_o | output | 1 | Receive output toward the controller |
| wake_irq_o | output | 1 | One-cycle wake interrupt (stop mode) |
| wake_rst_o | output | 1 | One-cycle system reset request (sleep mode) |
| wake_src_o | output | 1 | Sticky wake source flag |

## Verification
A counter that saturates early or clears late shows up as a pulse that appears for a dominant phase one cycle too short, or vanishes for one exactly at the limit. The sweep over every dominant length around the threshold exposes this on the third edge after release. A stale receive-only latch or armed state shows up as a pulse, or a missing one, on the first wake attempt after a mode change. A wrong mode decode shows up as the pulse leaving on the wrong output in that same cycle. A flag that fails to hold or clear is visible one cycle after the strobe.

// File: rtl/lin_wake_pkg.sv
package lin_wake_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_STOP   = 2'b01,
    MODE_SLEEP  = 2'b10,
    MODE_RSVD   = 2'b11
  } pwr_mode_e;

  function automatic logic is_low_power(input logic [1:0] m);
    return (m == MODE_STOP) || (m == MODE_SLEEP);
  endfunction

endpackage

// File: rtl/lin_wake_sync.sv
module lin_wake_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RESET_VAL;
        else     chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/lin_wake_timer.sv
module lin_wake_timer #(
  parameter int MIN_DOM_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic enable_i,
  input  logic bus_s_i,
  output logic hit_o
);

  localparam int CW = $clog2(MIN_DOM_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_DOM_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  // armed: recessive seen since detection was enabled
  always_ff @(posedge clk) begin
    if (rst || !enable_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_q | bus_s_i;
      if (bus_s_i)
        cnt_q <= '0;
      else if (armed_q && cnt_q != CNT_MAX)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_o = enable_i && armed_q && bus_s_i && (cnt_q == CNT_MAX);

endmodule

// File: rtl/lin_wake_ctrl.sv
module lin_wake_ctrl
  import lin_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       rx_only_i,
  input  logic       src_clr_i,
  input  logic       bus_s_i,
  input  logic       hit_i,
  output logic       det_en_o,
  output logic       tx_en_o,
  output logic       rxd_o,
  output logic       wake_irq_o,
  output logic       wake_rst_o,
  output logic       wake_src_o
);

  logic lp, lp_q, entry, rxo_lat_q, rxo_eff;

  assign lp       = is_low_power(mode_i);
  assign entry    = lp && !lp_q;
  assign rxo_eff  = entry ? rx_only_i : rxo_lat_q;
  assign det_en_o = lp && !rxo_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      lp_q      <= 1'b0;
      rxo_lat_q <= 1'b0;
    end else begin
      lp_q      <= lp;
      rxo_lat_q <= lp ? rxo_eff : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en_o    <= 1'b0;
      rxd_o      <= 1'b1;
      wake_irq_o <= 1'b0;
      wake_rst_o <= 1'b0;
      wake_src_o <= 1'b0;
    end else begin
      tx_en_o    <= !lp && !rx_only_i;
      if (!lp || (mode_i == MODE_STOP && rxo_eff))
        rxd_o <= bus_s_i;
      else
        rxd_o <= 1'b1;
      wake_irq_o <= hit_i && (mode_i == MODE_STOP);
      wake_rst_o <= hit_i && (mode_i == MODE_SLEEP);
      wake_src_o <= hit_i || (wake_src_o && !src_clr_i);
    end
  end

endmodule

// File: rtl/lin_wake_detector.sv
module lin_wake_detector #(
  parameter int MIN_DOM_CYCLES = 50000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_rx_i,
  input  logic [1:0] mode_i,
  input  logic       rx_only_i,
  input  logic       src_clr_i,
  output logic       tx_en_o,
  output logic       rxd_o,
  output logic       wake_irq_o,
  output logic       wake_rst_o,
  output logic       wake_src_o
);

  logic bus_s, det_en, hit;

  lin_wake_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (bus_rx_i),
    .q_o (bus_s)
  );

  lin_wake_timer #(.MIN_DOM_CYCLES(MIN_DOM_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .enable_i (det_en),
    .bus_s_i  (bus_s),
    .hit_o    (hit)
  );

  lin_wake_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .rx_only_i  (rx_only_i),
    .src_clr_i  (src_clr_i),
    .bus_s_i    (bus_s),
    .hit_i      (hit),
    .det_en_o   (det_en),
    .tx_en_o    (tx_en_o),
    .rxd_o      (rxd_o),
    .wake_irq_o (wake_irq_o),
    .wake_rst_o (wake_rst_o),
    .wake_src_o (wake_src_o)
  );

endmodule

// File: rtl/lin_wake_checker.sv
module lin_wake_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_rx_i,
  input logic [1:0] mode_i,
  input logic       rx_only_i,
  input logic       src_clr_i,
  input logic       tx_en_o,
  input logic       rxd_o,
  input logic       wake_irq_o,
  input logic       wake_rst_o,
  input logic       wake_src_o
);

  a_r1_tx_off_lowpower: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b01 || mode_i == 2'b10) |=> !tx_en_o);

  a_r3_irq_only_stop: assert property (@(posedge clk) disable iff (rst)
    (mode_i != 2'b01) |=> !wake_irq_o);

  a_r3_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
    wake_irq_o |=> !wake_irq_o);

  a_r4_rst_only_sleep: assert property (@(posedge clk) disable iff (rst)
    (mode_i != 2'b10) |=> !wake_rst_o);

  a_r4_rst_one_cycle: assert property (@(posedge clk) disable iff (rst)
    wake_rst_o |=> !wake_rst_o);

  a_r5_src_with_event: assert property (@(posedge clk) disable iff (rst)
    (wake_irq_o || wake_rst_o) |-> wake_src_o);

  a_r5_src_holds: assert property (@(posedge clk) disable iff (rst)
    (wake_src_o && !src_clr_i) |=> wake_src_o);

  a_r8_quiet_in_normal: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b00) |=> !(wake_irq_o || wake_rst_o));

endmodule

bind lin_wake_detector lin_wake_checker u_chk (.*);

// File: tb/sim_lin_wake_detector.sv
module sim_lin_wake_detector;

  localparam int MIN = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_rx_i = 1'b1;
  logic [1:0] mode_i = 2'b00;
  logic rx_only_i = 1'b0;
  logic src_clr_i = 1'b0;
  logic tx_en_o, rxd_o, wake_irq_o, wake_rst_o, wake_src_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  int irq_n, rst_n, first_at;

  always #4 clk = ~clk;

  lin_wake_detector #(.MIN_DOM_CYCLES(MIN), .SYNC_STAGES(2)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sample();
    @(negedge clk);
    if (wake_irq_o || wake_rst_o) begin
      if (first_at < 0) first_at = 0;
    end
    irq_n += int'(wake_irq_o);
    rst_n += int'(wake_rst_o);
  endtask

  // drive dominant for len cycles, release, watch; first_at counts negedges after release
  task automatic dom_pulse(input int len);
    irq_n = 0; rst_n = 0; first_at = -1;
    bus_rx_i = 1'b0;
    for (int i = 0; i < len; i++) sample();
    first_at = (first_at < 0) ? -1 : 99;
    bus_rx_i = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if ((wake_irq_o || wake_rst_o) && first_at < 0) first_at = i;
      irq_n += int'(wake_irq_o);
      rst_n += int'(wake_rst_o);
    end
  endtask

  task automatic clear_src();
    src_clr_i = 1'b1;
    @(negedge clk);
    src_clr_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic go_mode(input logic [1:0] m, input logic rxo);
    rx_only_i = rxo;
    mode_i = m;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 tx_en", tx_en_o, 0);
    chk("R10 rxd", rxd_o, 1);
    chk("R10 irq", wake_irq_o, 0);
    chk("R10 rst", wake_rst_o, 0);
    chk("R10 src", wake_src_o, 0);
    rst = 1'b0;

    // R1 transmitter enable per mode
    mode_i = 2'b00; rx_only_i = 1'b0; @(negedge clk);
    chk("R1 normal", tx_en_o, 1);
    rx_only_i = 1'b1; @(negedge clk);
    chk("R1 normal rx-only", tx_en_o, 0);
    rx_only_i = 1'b0; mode_i = 2'b11; @(negedge clk);
    chk("R1 mode 11", tx_en_o, 1);
    mode_i = 2'b01; @(negedge clk);
    chk("R1 stop", tx_en_o, 0);
    mode_i = 2'b10; @(negedge clk);
    chk("R1 sleep", tx_en_o, 0);

    // R7 normal-mode receive path latency
    go_mode(2'b00, 1'b0);
    bus_rx_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 normal latency 2", rxd_o, 1);
    @(negedge clk);
    chk("R7 normal latency 3", rxd_o, 0);
    bus_rx_i = 1'b1; repeat (3) @(negedge clk);

    // R2/R3/R5 sweep in stop mode, R2/R4/R5 in sleep mode
    for (int m = 0; m < 2; m++) begin
      go_mode(m == 0 ? 2'b01 : 2'b10, 1'b0);
      for (int len = 1; len <= MIN + 2; len++) begin
        automatic int ev = (len >= MIN) ? 1 : 0;
        dom_pulse(len);
        if (m == 0) begin
          chk($sformatf("R3 stop irq len=%0d", len), irq_n, ev);
          chk($sformatf("R3 stop no rst len=%0d", len), rst_n, 0);
        end else begin
          chk($sformatf("R4 sleep rst len=%0d", len), rst_n, ev);
          chk($sformatf("R4 sleep no irq len=%0d", len), irq_n, 0);
        end
        if (ev == 1) chk($sformatf("R2 timing len=%0d", len), first_at, 3);
        chk($sformatf("R5 src len=%0d", len), wake_src_o, ev);
        repeat (3) @(negedge clk);
        chk($sformatf("R5 src holds len=%0d", len), wake_src_o, ev);
        clear_src();
        chk($sformatf("R5 src cleared len=%0d", len), wake_src_o, 0);
      end
    end

    // R9 long dominant, saturating counter
    go_mode(2'b01, 1'b0);
    dom_pulse(300);
    chk("R9 long irq count", irq_n, 1);
    chk("R9 long timing", first_at, 3);
    clear_src();

    // R6 rx-only latched at stop entry; R7 rxd follows bus
    go_mode(2'b00, 1'b0);
    go_mode(2'b01, 1'b1);
    rx_only_i = 1'b0;
    bus_rx_i = 1'b0; repeat (3) @(negedge clk);
    chk("R7 stop rx-only rxd low", rxd_o, 0);
    bus_rx_i = 1'b1; repeat (3) @(negedge clk);
    chk("R7 stop rx-only rxd high", rxd_o, 1);
    dom_pulse(MIN + 2);
    chk("R6 stop rx-only no irq", irq_n, 0);
    chk("R6 stop rx-only no src", wake_src_o, 0);

    // R6 sleep with rx-only; R7 rxd held high
    go_mode(2'b00, 1'b0);
    go_mode(2'b10, 1'b1);
    rx_only_i = 1'b0;
    bus_rx_i = 1'b0; repeat (3) @(negedge clk);
    chk("R7 sleep rxd held", rxd_o, 1);
    bus_rx_i = 1'b1; repeat (3) @(negedge clk);
    dom_pulse(MIN + 2);
    chk("R6 sleep rx-only no rst", rst_n, 0);

    // R7 stop without rx-only holds rxd high
    go_mode(2'b00, 1'b0);
    go_mode(2'b01, 1'b0);
    bus_rx_i = 1'b0; repeat (3) @(negedge clk);
    chk("R7 stop rxd held", rxd_o, 1);
    bus_rx_i = 1'b1; repeat (3) @(negedge clk);
    clear_src();

    // R8 dominant started in normal mode
    go_mode(2'b00, 1'b0);
    bus_rx_i = 1'b0; repeat (3) @(negedge clk);
    mode_i = 2'b01;
    dom_pulse(MIN + 3);
    chk("R8 pre-entry dominant no irq", irq_n, 0);
    chk("R8 pre-entry dominant no src", wake_src_o, 0);

    // R8 return to normal discards counted time
    repeat (4) @(negedge clk);
    bus_rx_i = 1'b0; repeat (MIN - 2) @(negedge clk);
    mode_i = 2'b00; repeat (2) @(negedge clk);
    mode_i = 2'b01;
    dom_pulse(3);
    chk("R8 normal detour no irq", irq_n, 0);
    chk("R8 normal detour no src", wake_src_o, 0);

    // R3 detection resumes afterwards
    repeat (4) @(negedge clk);
    dom_pulse(MIN);
    chk("R3 resumes after detour", irq_n, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule